// File: doc/BRIEF.md
# Shared Local Bus Cycle Sequencer

This block is the control state machine of a network adapter card. The card has one on-card bus, and two masters share it. The first master is the host slave interface, which serves host reads and writes to the buffer RAM, the identification ROM and the controller registers. The second master is the network controller's DMA engine. The sequencer runs on the host bus clock. It decides which master owns the bus, and it steps each host cycle through a fixed series of states. The length of that series depends on the cycle type.

There are seven states. One state is idle. Five states serve host cycles. One state means the DMA engine owns the bus. The machine looks at requests only while it is idle, and a DMA request wins over a host request when both are waiting. A DMA owner keeps the bus for its whole burst. A host cycle that arrives during that time stays pending and starts once the bus comes back to idle.

A RAM access takes four states because a 32-bit host word is split into two half-word accesses. The machine drives a half select and a capture strobe for the first half. Register cycles wait for an acknowledge from the controller, which runs on another clock. The DMA request also comes from that other clock. Both of these inputs pass through a flip-flop synchronizer before the machine uses them.

Top module: `lbus_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `host_ack`, `dma_gnt`, `data_stb`, `cap_stb` and `half_sel` are low and `ack_status` is 2'b00.
- R2: RAM cycle (`tgt_sel` = 2'b00). Raise `slot_go` while the machine is idle. `host_ack` rises after the fourth rising clock edge. In the four cycles of the access, `cap_stb` is high only in the second cycle and `half_sel` is high only in the third and fourth cycles.
- R3: ROM read (`tgt_sel` = 2'b01). `host_ack` rises after the second rising clock edge following `slot_go`.
- R4: Register cycle (`tgt_sel` = 2'b10). The machine holds its first host state, with no acknowledge, until `reg_ack` has passed the synchronizer. `host_ack` rises after the third rising edge following the rise of `reg_ack`, and not earlier.
- R5: Bus error. The target `tgt_sel` = 2'b11, or `err_req` high, ends the cycle after the second edge with `ack_status` = 2'b10 and `data_stb` low in the acknowledge cycle. `err_req` takes precedence over any target.
- R6: `host_ack` is high for exactly one cycle per host access. With it, `ack_status` is 2'b01 for a completed transfer. When no acknowledge is driven, `ack_status` is 2'b00.
- R7: `dma_gnt` rises after the third rising edge following the rise of `dma_req`. It falls after the third rising edge following the fall of `dma_req`.
- R8: If the synchronized DMA request and `slot_go` are both high while idle, the DMA master is granted first and no host strobe is driven.
- R9: While `dma_gnt` is high, the host cycle stays pending: `data_stb` and `host_ack` stay low. A RAM cycle whose `slot_go` is still held then acknowledges 7 edges after `dma_req` falls.
- R10: `data_stb` is high only in the first, third and fourth host states. `cap_stb` and `data_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_go | input | 1 | Host cycle addressed to this card; held until acknowledged |
| tgt_sel | input | 2 | Target decode: 00 RAM, 01 ROM, 10 register, 11 none |
| err_req | input | 1 | Force a bus-error completion (for example a ROM write) |
| dma_req | input | 1 | DMA bus request, asynchronous |
| reg_ack | input | 1 | Register access acknowledge, asynchronous |
| data_stb | output | 1 | Data strobe qualifying the data enables |
| half_sel | output | 1 | Selects the second half-word of a RAM access |
| cap_stb | output | 1 | Top-half qualifier / capture strobe of the first half-word |
| host_ack | output | 1 | Host cycle acknowledge |
| ack_status | output | 2 | 01 transfer complete, 10 bus error, 00 no acknowledge |
| dma_gnt | output | 1 | Local bus granted to the DMA master |

## Verification
A wrong state shows up at the ports within a single cycle, because every output is decoded directly from the state register. A path that skips a state changes the cycle count to `host_ack`, or moves `cap_stb` and `half_sel` out of place. An arbitration fault shows as a host strobe while `dma_gnt` is high, or as a grant that comes late. An error in the synchronizer depth moves the grant edges and the register acknowledge by whole cycles. The bench therefore measures these edges to the exact cycle.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HS1  = 3'd1,
        ST_HS2  = 3'd2,
        ST_HS3  = 3'd3,
        ST_HACK = 3'd4,
        ST_HERR = 3'd5,
        ST_DMA  = 3'd6
    } seq_state_e;

    localparam int TGT_W = 2;
    localparam logic [TGT_W-1:0] TGT_RAM  = 2'b00;
    localparam logic [TGT_W-1:0] TGT_ROM  = 2'b01;
    localparam logic [TGT_W-1:0] TGT_REG  = 2'b10;
    localparam logic [TGT_W-1:0] TGT_NONE = 2'b11;

    localparam int STS_W = 2;
    localparam logic [STS_W-1:0] STS_NONE = 2'b00;
    localparam logic [STS_W-1:0] STS_DONE = 2'b01;
    localparam logic [STS_W-1:0] STS_ERR  = 2'b10;

    typedef struct packed {
        seq_state_e st;
        logic       is_ram;
    } seq_regs_t;
endpackage

// File: rtl/lbus_sync.sv
module lbus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] src_d;
            if (g == 0) begin : g_first
                assign src_d = async_i;
            end else begin : g_next
                assign src_d = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= src_d;
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lbus_fsm.sv
module lbus_fsm
    import lbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_go,
    input  logic [TGT_W-1:0] tgt_sel,
    input  logic             err_req,
    input  logic             dma_s,
    input  logic             rack_s,
    output logic             data_stb,
    output logic             half_sel,
    output logic             cap_stb,
    output logic             host_ack,
    output logic [STS_W-1:0] ack_status,
    output logic             dma_gnt
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (dma_s)        r_d.st = ST_DMA;
                else if (slot_go) r_d.st = ST_HS1;
            end
            ST_HS1: begin
                if (err_req || tgt_sel == TGT_NONE) begin
                    r_d.st = ST_HERR;
                end else if (tgt_sel == TGT_RAM) begin
                    r_d.st     = ST_HS2;
                    r_d.is_ram = 1'b1;
                end else if (tgt_sel == TGT_ROM) begin
                    r_d.st = ST_HACK;
                end else if (rack_s) begin
                    r_d.st = ST_HACK;
                end
            end
            ST_HS2:  r_d.st = ST_HS3;
            ST_HS3:  r_d.st = ST_HACK;
            ST_HACK, ST_HERR: begin
                r_d.st     = ST_IDLE;
                r_d.is_ram = 1'b0;
            end
            ST_DMA:  if (!dma_s) r_d.st = ST_IDLE;
            default: begin
                r_d.st     = ST_IDLE;
                r_d.is_ram = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, is_ram: 1'b0};
        else        r_q <= r_d;
    end

    assign data_stb   = (r_q.st == ST_HS1) || (r_q.st == ST_HS3) || (r_q.st == ST_HACK);
    assign cap_stb    = (r_q.st == ST_HS2);
    assign half_sel   = r_q.is_ram && ((r_q.st == ST_HS3) || (r_q.st == ST_HACK));
    assign host_ack   = (r_q.st == ST_HACK) || (r_q.st == ST_HERR);
    assign ack_status = (r_q.st == ST_HACK) ? STS_DONE :
                        (r_q.st == ST_HERR) ? STS_ERR  : STS_NONE;
    assign dma_gnt    = (r_q.st == ST_DMA);

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    assert_ack_back_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> (r_q.st == ST_IDLE));
    assert_grant_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_gnt) |-> ($past(r_q.st) == ST_IDLE && $past(dma_s)));
    assert_host_quiet_in_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_gnt |-> !(data_stb || host_ack || cap_stb));
    assert_err_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_status == STS_ERR) |-> !data_stb);
    assert_cap_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> !data_stb);
    assert_cap_then_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> (half_sel && data_stb));
    assert_reg_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HS1 && tgt_sel == TGT_REG && !err_req && !rack_s) |=> (r_q.st == ST_HS1));
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_go,
    input  logic [1:0] tgt_sel,
    input  logic       err_req,
    input  logic       dma_req,
    input  logic       reg_ack,
    output logic       data_stb,
    output logic       half_sel,
    output logic       cap_stb,
    output logic       host_ack,
    output logic [1:0] ack_status,
    output logic       dma_gnt
);
    localparam int XW = 2;
    logic [XW-1:0] x_async, x_sync;

    assign x_async = {reg_ack, dma_req};

    lbus_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (x_async),
        .sync_o  (x_sync)
    );

    lbus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_go    (slot_go),
        .tgt_sel    (tgt_sel),
        .err_req    (err_req),
        .dma_s      (x_sync[0]),
        .rack_s     (x_sync[1]),
        .data_stb   (data_stb),
        .half_sel   (half_sel),
        .cap_stb    (cap_stb),
        .host_ack   (host_ack),
        .ack_status (ack_status),
        .dma_gnt    (dma_gnt)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(host_ack || dma_gnt));
endmodule

// File: tb/lbus_seq_tb.sv
module lbus_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_go = 1'b0;
    logic [1:0] tgt_sel = 2'b00;
    logic err_req = 1'b0;
    logic dma_req = 1'b0;
    logic reg_ack = 1'b0;
    logic data_stb, half_sel, cap_stb, host_ack, dma_gnt;
    logic [1:0] ack_status;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .tgt_sel(tgt_sel),
        .err_req(err_req), .dma_req(dma_req), .reg_ack(reg_ack),
        .data_stb(data_stb), .half_sel(half_sel), .cap_stb(cap_stb),
        .host_ack(host_ack), .ack_status(ack_status), .dma_gnt(dma_gnt)
    );

    typedef struct packed {
        logic [1:0] tgt;
        logic       err;
        logic [3:0] lat;
        logic [1:0] sts;
        logic [3:0] stb;
        logic [3:0] cap;
        logic [3:0] half;
    } vec_t;

    // R2 RAM, R3 ROM, R5 no device, R5 error on ROM, R5 error on RAM
    localparam vec_t VECS [5] = '{
        '{tgt: 2'b00, err: 1'b0, lat: 4'd4, sts: 2'b01, stb: 4'b1101, cap: 4'b0010, half: 4'b1100},
        '{tgt: 2'b01, err: 1'b0, lat: 4'd2, sts: 2'b01, stb: 4'b0011, cap: 4'b0000, half: 4'b0000},
        '{tgt: 2'b11, err: 1'b0, lat: 4'd2, sts: 2'b10, stb: 4'b0001, cap: 4'b0000, half: 4'b0000},
        '{tgt: 2'b01, err: 1'b1, lat: 4'd2, sts: 2'b10, stb: 4'b0001, cap: 4'b0000, half: 4'b0000},
        '{tgt: 2'b00, err: 1'b1, lat: 4'd2, sts: 2'b10, stb: 4'b0001, cap: 4'b0000, half: 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait for host_ack, counting negedges; records strobe patterns.
    task automatic run_host(output int lat, output logic [1:0] sts,
                            output logic [3:0] stb, output logic [3:0] cap,
                            output logic [3:0] half);
        lat = 0; sts = 2'b00; stb = '0; cap = '0; half = '0;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (n <= 4) begin
                stb[n-1]  = data_stb;
                cap[n-1]  = cap_stb;
                half[n-1] = half_sel;
            end
            if (host_ack) begin
                lat = n;
                sts = ack_status;
                break;
            end
        end
        slot_go = 1'b0;
        err_req = 1'b0;
    endtask

    initial begin
        int lat;
        logic [1:0] sts;
        logic [3:0] stb, cap, half;
        string tag;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ack in reset", host_ack, 0);
        chk("R1 gnt in reset", dma_gnt, 0);
        chk("R1 strobes in reset", {data_stb, cap_stb, half_sel, ack_status}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {host_ack, dma_gnt, data_stb, cap_stb, half_sel, ack_status}, 0);

        // Vector table walk
        foreach (VECS[i]) begin
            tag = (VECS[i].sts == 2'b10) ? "R5" : (VECS[i].tgt == 2'b00 ? "R2" : "R3");
            tgt_sel = VECS[i].tgt;
            err_req = VECS[i].err;
            slot_go = 1'b1;
            run_host(lat, sts, stb, cap, half);
            chk({tag, " latency"}, lat, VECS[i].lat);
            chk({"R6 status ", tag}, sts, VECS[i].sts);
            chk({"R10 data strobe ", tag}, stb, VECS[i].stb);
            chk({tag, " capture strobe"}, cap, VECS[i].cap);
            chk({tag, " half select"}, half, VECS[i].half);
            @(negedge clk);
            chk("R6 single ack", {host_ack, ack_status}, 0);
        end

        // R4: register cycle waits on synchronized acknowledge
        tgt_sel = 2'b10;
        slot_go = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 held without ack", {host_ack, data_stb}, 2'b01);
        reg_ack = 1'b1;
        @(negedge clk);
        chk("R4 early ack edge1", host_ack, 0);
        @(negedge clk);
        chk("R4 early ack edge2", host_ack, 0);
        @(negedge clk);
        chk("R4 ack after sync", {host_ack, ack_status}, 3'b101);
        slot_go = 1'b0;
        reg_ack = 1'b0;
        repeat (4) @(negedge clk);

        // R7: grant timing, R9: host pending during grant
        dma_req = 1'b1;
        @(negedge clk);
        chk("R7 gnt edge1", dma_gnt, 0);
        @(negedge clk);
        chk("R7 gnt edge2", dma_gnt, 0);
        @(negedge clk);
        chk("R7 gnt edge3", dma_gnt, 1);
        tgt_sel = 2'b00;
        slot_go = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 host held during grant", {dma_gnt, data_stb, host_ack}, 3'b100);
        dma_req = 1'b0;
        run_host(lat, sts, stb, cap, half);
        chk("R9 pending RAM cycle after release", lat, 7);
        chk("R7 gnt released", dma_gnt, 0);
        repeat (3) @(negedge clk);

        // R8: priority when both pending in idle
        dma_req = 1'b1;
        repeat (2) @(negedge clk);
        tgt_sel = 2'b01;
        slot_go = 1'b1;
        @(negedge clk);
        chk("R8 DMA wins", {dma_gnt, data_stb}, 2'b10);
        dma_req = 1'b0;
        run_host(lat, sts, stb, cap, half);
        chk("R8 host served after DMA", lat, 5);
        repeat (3) @(negedge clk);

        // R1: reset in the middle of a RAM cycle
        tgt_sel = 2'b00;
        slot_go = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        slot_go = 1'b0;
        @(negedge clk);
        chk("R1 mid-cycle reset", {host_ack, dma_gnt, data_stb, cap_stb, half_sel}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {host_ack, data_stb}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule